// File: doc/BRIEF.md
# Fuse-ROM Hard-Repair Programming Controller

This controller makes a memory repair permanent. After a self-test and soft-repair pass has left repair data in each memory's fuse register segment, a program run walks the memories in index order. For every memory flagged as repaired that has no record in the fuse ROM yet, it writes a header word to the ROM. It then shifts that memory's segment out serially, packs the bits into ROM-width words and writes each word behind the header. Segments are reached through bypass selection, so exactly one memory's segment sits between the serial input and output at a time. During the unload, the serial output is fed straight back into the segment, so the soft repair stays in place.

At power-up a load run reads the ROM from address 0. Each valid header names a memory, and the data words that follow it are shifted into that memory's segment. Memories with no record are never selected. Incremental repair works because a program run first walks the records already in the ROM. It appends new records after the last one and skips memories that already own a record. A record that would run past the end of the ROM aborts the run and sets a sticky error flag.

Top module: `fuse_rom_repair_ctrl`

States: IDLE, SCAN_RD (read a header during the incremental walk), SCAN_CHK (accept the header and jump over its record, or stop the walk), PICK (choose the lowest pending memory), FIT (check the record fits), HDR (write the header), USHIFT (shift out and capture one bit), UWRITE (write a packed word), LHDR_RD and LHDR_CHK (read and decode a header on load), LDATA_RD and LDATA_LAT (fetch a data word), LSHIFT (shift one bit in), FINISH (one-cycle completion).

Transitions:
- IDLE goes to SCAN_RD on start_prog, or to LHDR_RD on start_load.
- SCAN_RD goes to PICK at the ROM end, otherwise to SCAN_CHK.
- SCAN_CHK goes back to SCAN_RD on a valid header, otherwise to PICK.
- PICK goes to FIT when a memory is pending, otherwise to FINISH.
- FIT goes to FINISH with the error set when the record does not fit, otherwise to HDR.
- HDR goes to USHIFT, or to PICK for a zero-length segment.
- USHIFT goes to UWRITE when a word is full or the last bit has been taken.
- UWRITE goes to PICK when the segment is done, otherwise back to USHIFT.
- LHDR_RD goes to FINISH at the ROM end, otherwise to LHDR_CHK.
- LHDR_CHK goes to FINISH on an invalid header, to LHDR_RD for a zero-length segment, otherwise to LDATA_RD.
- LDATA_RD goes to FINISH at the ROM end, otherwise to LDATA_LAT.
- LDATA_LAT goes to LSHIFT.
- LSHIFT goes to LHDR_RD after the segment's last bit, or to LDATA_RD when the word is used up.
- FINISH goes to IDLE.

## Requirements
- R1: After reset busy, done, err_full, rom_wr, rom_rd, chain_shift and chain_sel are all 0.
- R2: A record is one header word followed by ceil(len/ROM_W) data words. In the header, bit ROM_W-1 is the valid bit (1), bits [ID_W-1:0] hold the memory index, and all other bits are 0. The first bit shifted out of the segment lands in bit 0 of the first data word, later bits go to rising positions, and the last word is zero-padded.
- R3: During a program run, chain_si equals chain_so on every shift, and each recorded segment is shifted exactly len times, so every segment ends with its original contents.
- R4: Only memories with mem_repaired set get a record, and records are appended in increasing memory index order.
- R5: A program run first follows existing records from address 0. A header counts as valid when bit ROM_W-1 is set, its reserved bits are 0 and its index is below NUM_MEM. New records start at the first word that is not a valid header, and memories that already have a record are skipped.
- R6: If a record would extend past ROM_DEPTH, the run writes none of its words, shifts nothing, sets err_full and ends. err_full stays set through later runs until reset.
- R7: A load run follows the records from address 0, shifts each record's len bits into the named segment in stored order, stops at the first invalid header or at the ROM end, and never selects a memory that has no record.
- R8: chain_shift is only ever high with exactly one bit of chain_sel set.
- R9: start_prog takes priority over start_load in the same cycle. Starts arriving while busy are ignored. done is a single-cycle pulse at the end of every run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_prog | input | 1 | Pulse: start a program run |
| start_load | input | 1 | Pulse: start a load run |
| mem_repaired | input | NUM_MEM | Per-memory repaired flag |
| mem_len | input | NUM_MEM*LEN_W | Per-memory segment length, memory i at bits [i*LEN_W +: LEN_W] |
| chain_so | input | 1 | Serial output bit of the selected segment |
| chain_si | output | 1 | Serial input bit to the selected segment |
| chain_shift | output | 1 | Shift enable for the selected segment |
| chain_sel | output | NUM_MEM | One-hot segment select; unselected segments are bypassed |
| rom_addr | output | clog2(ROM_DEPTH) | ROM word address |
| rom_wr | output | 1 | ROM write strobe |
| rom_wdata | output | ROM_W | ROM write data |
| rom_rd | output | 1 | ROM read strobe; data returns on rom_rdata one cycle later |
| rom_rdata | input | ROM_W | ROM read data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| err_full | output | 1 | Sticky ROM-full error |

## Verification
The hardest situation to reach is the ROM-full abort. It needs a ROM that already holds records up to a point where the next pending record cannot fit. The bench fills its behavioural ROM through a back door with seven valid records, which leaves two free words, and then asks for a memory that needs three. Incremental appends are reached by running program passes back to back without clearing the ROM, with different repaired masks. Each program pass is followed by a load into scrambled segments, so the stored image is checked again through the serial path.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SCAN_RD,
        ST_SCAN_CHK,
        ST_PICK,
        ST_FIT,
        ST_HDR,
        ST_USHIFT,
        ST_UWRITE,
        ST_LHDR_RD,
        ST_LHDR_CHK,
        ST_LDATA_RD,
        ST_LDATA_LAT,
        ST_LSHIFT,
        ST_FINISH
    } hrp_state_e;

endpackage

// File: rtl/hrp_rec_sizer.sv
module hrp_rec_sizer #(
    parameter int NUM_MEM = 4,
    parameter int LEN_W   = 5,
    parameter int ROM_W   = 8,
    parameter int ID_W    = 2
) (
    input  logic [ID_W-1:0]          id,
    input  logic [NUM_MEM*LEN_W-1:0] mem_len,
    output logic [LEN_W-1:0]         seg_len,
    output logic [LEN_W:0]           data_words
);

    logic [LEN_W-1:0] lens [NUM_MEM];

    for (genvar g = 0; g < NUM_MEM; g++) begin : g_unpack
        assign lens[g] = mem_len[g*LEN_W +: LEN_W];
    end

    always_comb begin
        seg_len = '0;
        for (int i = 0; i < NUM_MEM; i++) begin
            if (id == ID_W'(i)) begin
                seg_len = lens[i];
            end
        end
    end

    // Words needed to hold the segment, last one zero-padded
    always_comb begin
        int unsigned nwords;
        nwords     = (int'(seg_len) + ROM_W - 1) / ROM_W;
        data_words = (LEN_W+1)'(nwords);
    end

endmodule

// File: rtl/hrp_next_pick.sv
module hrp_next_pick #(
    parameter int NUM_MEM = 4,
    parameter int ID_W    = 2
) (
    input  logic [NUM_MEM-1:0] pending,
    output logic               found,
    output logic [ID_W-1:0]    idx
);

    // Lowest pending index wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_MEM - 1; i >= 0; i--) begin
            if (pending[i]) begin
                found = 1'b1;
                idx   = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/hrp_bit_slicer.sv
module hrp_bit_slicer #(
    parameter int ROM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  logic [ROM_W-1:0] ld_word,
    input  logic             cap,
    input  logic             cap_bit,
    input  logic             adv,
    output logic [ROM_W-1:0] word,
    output logic             bit_out,
    output logic             at_last
);

    localparam int IW = (ROM_W > 1) ? $clog2(ROM_W) : 1;

    logic [IW:0] pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            pos  <= '0;
        end else if (clr) begin
            word <= '0;
            pos  <= '0;
        end else if (ld) begin
            word <= ld_word;
            pos  <= '0;
        end else if (cap) begin
            word[pos[IW-1:0]] <= cap_bit;
            pos               <= pos + 1'b1;
        end else if (adv) begin
            pos <= pos + 1'b1;
        end
    end

    assign bit_out = word[pos[IW-1:0]];
    assign at_last = (pos == (IW+1)'(ROM_W - 1));

    // The controller must re-arm the slicer before the word overruns
    assert_pos_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= (IW+1)'(ROM_W));

    assert_no_step_past_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == (IW+1)'(ROM_W)) |-> !(cap || adv));

endmodule

// File: rtl/fuse_rom_repair_ctrl.sv
module fuse_rom_repair_ctrl
    import hrp_pkg::*;
#(
    parameter int NUM_MEM   = 4,
    parameter int LEN_W     = 5,
    parameter int ROM_W     = 8,
    parameter int ROM_DEPTH = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start_prog,
    input  logic                                  start_load,
    input  logic [NUM_MEM-1:0]                    mem_repaired,
    input  logic [NUM_MEM*LEN_W-1:0]              mem_len,
    input  logic                                  chain_so,
    output logic                                  chain_si,
    output logic                                  chain_shift,
    output logic [NUM_MEM-1:0]                    chain_sel,
    output logic [$clog2(ROM_DEPTH)-1:0]          rom_addr,
    output logic                                  rom_wr,
    output logic [ROM_W-1:0]                      rom_wdata,
    output logic                                  rom_rd,
    input  logic [ROM_W-1:0]                      rom_rdata,
    output logic                                  busy,
    output logic                                  done,
    output logic                                  err_full
);

    localparam int ID_W = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1;
    localparam int AW   = $clog2(ROM_DEPTH);
    localparam int PW   = $clog2(ROM_DEPTH + 1);
    localparam int SW   = PW + LEN_W + 2;

    hrp_state_e state, state_nx;

    logic [PW-1:0]      ptr;
    logic [ID_W-1:0]    cur;
    logic [NUM_MEM-1:0] seen;
    logic [LEN_W-1:0]   remain;

    logic [ID_W-1:0]    hdr_id;
    logic               hdr_ok;
    logic [ID_W-1:0]    sz_id;
    logic [LEN_W-1:0]   seg_len;
    logic [LEN_W:0]     data_words;
    logic [SW-1:0]      span_end;
    logic               no_fit;
    logic               ptr_at_end;
    logic               pick_found;
    logic [ID_W-1:0]    pick_idx;
    logic [ROM_W-1:0]   hdr_word;

    logic               sl_clr, sl_ld, sl_cap, sl_adv;
    logic [ROM_W-1:0]   sl_word;
    logic               sl_bit, sl_last;

    // Header decode: valid bit, reserved bits clear, index in range
    assign hdr_id = rom_rdata[ID_W-1:0];
    assign hdr_ok = rom_rdata[ROM_W-1]
                 && ((rom_rdata[ROM_W-2:0] >> ID_W) == '0)
                 && ({1'b0, hdr_id} < (ID_W+1)'(NUM_MEM));

    assign sz_id = ((state == ST_SCAN_CHK) || (state == ST_LHDR_CHK)) ? hdr_id : cur;

    hrp_rec_sizer #(
        .NUM_MEM (NUM_MEM),
        .LEN_W   (LEN_W),
        .ROM_W   (ROM_W),
        .ID_W    (ID_W)
    ) u_sizer (
        .id         (sz_id),
        .mem_len    (mem_len),
        .seg_len    (seg_len),
        .data_words (data_words)
    );

    hrp_next_pick #(
        .NUM_MEM (NUM_MEM),
        .ID_W    (ID_W)
    ) u_pick (
        .pending (mem_repaired & ~seen),
        .found   (pick_found),
        .idx     (pick_idx)
    );

    hrp_bit_slicer #(
        .ROM_W (ROM_W)
    ) u_slicer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sl_clr),
        .ld      (sl_ld),
        .ld_word (rom_rdata),
        .cap     (sl_cap),
        .cap_bit (chain_so),
        .adv     (sl_adv),
        .word    (sl_word),
        .bit_out (sl_bit),
        .at_last (sl_last)
    );

    assign span_end   = SW'(ptr) + SW'(data_words) + SW'(1);
    assign no_fit     = span_end > SW'(ROM_DEPTH);
    assign ptr_at_end = ptr >= PW'(ROM_DEPTH);

    always_comb begin
        hdr_word                  = '0;
        hdr_word[ROM_W-1]         = 1'b1;
        hdr_word[ID_W-1:0]        = cur;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_prog) begin
                    state_nx = ST_SCAN_RD;
                end else if (start_load) begin
                    state_nx = ST_LHDR_RD;
                end
            end
            ST_SCAN_RD:   state_nx = ptr_at_end ? ST_PICK : ST_SCAN_CHK;
            ST_SCAN_CHK:  state_nx = hdr_ok ? ST_SCAN_RD : ST_PICK;
            ST_PICK:      state_nx = pick_found ? ST_FIT : ST_FINISH;
            ST_FIT:       state_nx = no_fit ? ST_FINISH : ST_HDR;
            ST_HDR:       state_nx = (seg_len == '0) ? ST_PICK : ST_USHIFT;
            ST_USHIFT: begin
                if ((remain == LEN_W'(1)) || sl_last) begin
                    state_nx = ST_UWRITE;
                end
            end
            ST_UWRITE:    state_nx = (remain == '0) ? ST_PICK : ST_USHIFT;
            ST_LHDR_RD:   state_nx = ptr_at_end ? ST_FINISH : ST_LHDR_CHK;
            ST_LHDR_CHK: begin
                if (!hdr_ok) begin
                    state_nx = ST_FINISH;
                end else if (seg_len == '0) begin
                    state_nx = ST_LHDR_RD;
                end else begin
                    state_nx = ST_LDATA_RD;
                end
            end
            ST_LDATA_RD:  state_nx = ptr_at_end ? ST_FINISH : ST_LDATA_LAT;
            ST_LDATA_LAT: state_nx = ST_LSHIFT;
            ST_LSHIFT: begin
                if (remain == LEN_W'(1)) begin
                    state_nx = ST_LHDR_RD;
                end else if (sl_last) begin
                    state_nx = ST_LDATA_RD;
                end
            end
            ST_FINISH:    state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Walk pointer, segment bookkeeping and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr      <= '0;
            cur      <= '0;
            seen     <= '0;
            remain   <= '0;
            err_full <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_prog || start_load) begin
                        ptr  <= '0;
                        cur  <= '0;
                        seen <= '0;
                    end
                end
                ST_SCAN_CHK: begin
                    if (hdr_ok) begin
                        seen[hdr_id] <= 1'b1;
                        ptr <= no_fit ? PW'(ROM_DEPTH) : PW'(span_end);
                    end
                end
                ST_PICK: begin
                    if (pick_found) begin
                        cur <= pick_idx;
                    end
                end
                ST_FIT: begin
                    if (no_fit) begin
                        err_full <= 1'b1;
                    end
                end
                ST_HDR: begin
                    ptr    <= ptr + 1'b1;
                    remain <= seg_len;
                    if (seg_len == '0) begin
                        seen[cur] <= 1'b1;
                    end
                end
                ST_USHIFT: begin
                    remain <= remain - 1'b1;
                end
                ST_UWRITE: begin
                    ptr <= ptr + 1'b1;
                    if (remain == '0) begin
                        seen[cur] <= 1'b1;
                    end
                end
                ST_LHDR_CHK: begin
                    if (hdr_ok) begin
                        cur    <= hdr_id;
                        remain <= seg_len;
                        ptr    <= ptr + 1'b1;
                    end
                end
                ST_LDATA_LAT: begin
                    ptr <= ptr + 1'b1;
                end
                ST_LSHIFT: begin
                    remain <= remain - 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        sl_clr      = 1'b0;
        sl_ld       = 1'b0;
        sl_cap      = 1'b0;
        sl_adv      = 1'b0;
        rom_rd      = 1'b0;
        rom_wr      = 1'b0;
        rom_wdata   = '0;
        chain_sel   = '0;
        chain_shift = 1'b0;
        chain_si    = 1'b0;
        rom_addr    = ptr[AW-1:0];
        busy        = (state != ST_IDLE);
        done        = (state == ST_FINISH);
        unique case (state)
            ST_SCAN_RD, ST_LHDR_RD, ST_LDATA_RD: begin
                rom_rd = !ptr_at_end;
            end
            ST_HDR: begin
                rom_wr    = 1'b1;
                rom_wdata = hdr_word;
                sl_clr    = 1'b1;
            end
            ST_USHIFT: begin
                chain_sel   = NUM_MEM'(1) << cur;
                chain_shift = 1'b1;
                chain_si    = chain_so;
                sl_cap      = 1'b1;
            end
            ST_UWRITE: begin
                rom_wr    = 1'b1;
                rom_wdata = sl_word;
                sl_clr    = 1'b1;
            end
            ST_LDATA_LAT: begin
                sl_ld = 1'b1;
            end
            ST_LSHIFT: begin
                chain_sel   = NUM_MEM'(1) << cur;
                chain_shift = 1'b1;
                chain_si    = sl_bit;
                sl_adv      = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assert_wr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rom_wr |-> (ptr < PW'(ROM_DEPTH)));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_full |=> err_full);

    assert_single_seg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chain_shift |-> ($countones(chain_sel) == 1));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((chain_sel == '0) && !chain_shift && !rom_wr && !rom_rd));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_port_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_rd && rom_wr));

endmodule

// File: tb/fuse_rom_repair_ctrl_bench.sv
module fuse_rom_repair_ctrl_bench;

    localparam int NM = 4;
    localparam int LW = 5;
    localparam int RW = 8;
    localparam int RD = 16;
    localparam int LENS [NM] = '{11, 8, 3, 16};
    // {clear rom, repaired mask, expected first free word}
    localparam logic [9:0] VEC [6] = '{
        {1'b1, 4'b0101, 5'd5},
        {1'b0, 4'b1111, 5'd10},
        {1'b0, 4'b1111, 5'd10},
        {1'b1, 4'b0000, 5'd0},
        {1'b1, 4'b1010, 5'd5},
        {1'b0, 4'b1111, 5'd10}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_prog = 1'b0;
    logic          start_load = 1'b0;
    logic [NM-1:0] mem_repaired = '0;
    logic [NM*LW-1:0] mem_len;
    logic          chain_so;
    logic          chain_si;
    logic          chain_shift;
    logic [NM-1:0] chain_sel;
    logic [3:0]    rom_addr;
    logic          rom_wr;
    logic [RW-1:0] rom_wdata;
    logic          rom_rd;
    logic [RW-1:0] rom_rdata = '0;
    logic          busy, done, err_full;

    assign mem_len = {5'd16, 5'd3, 5'd8, 5'd11};

    always #5 clk = ~clk;

    fuse_rom_repair_ctrl #(
        .NUM_MEM   (NM),
        .LEN_W     (LW),
        .ROM_W     (RW),
        .ROM_DEPTH (RD)
    ) u_fuse_rom_repair_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_prog   (start_prog),
        .start_load   (start_load),
        .mem_repaired (mem_repaired),
        .mem_len      (mem_len),
        .chain_so     (chain_so),
        .chain_si     (chain_si),
        .chain_shift  (chain_shift),
        .chain_sel    (chain_sel),
        .rom_addr     (rom_addr),
        .rom_wr       (rom_wr),
        .rom_wdata    (rom_wdata),
        .rom_rd       (rom_rd),
        .rom_rdata    (rom_rdata),
        .busy         (busy),
        .done         (done),
        .err_full     (err_full)
    );

    // Behavioural ROM and fuse segments, with back-door requests from the bench
    logic [RW-1:0] rom [RD];
    logic [15:0]   seg [NM];
    logic          seg_wr = 1'b0, rom_set = 1'b0, rom_clr = 1'b0, in_prog = 1'b0;
    int            seg_wi = 0, rom_si = 0;
    logic [15:0]   seg_wv = '0;
    logic [RW-1:0] rom_sv = '0;
    int            shift_total = 0, bad_sel = 0, recirc_bad = 0, done_cnt = 0;

    function automatic logic [15:0] lmask(int i);
        return 16'((32'h1 << LENS[i]) - 1);
    endfunction

    always_comb begin
        chain_so = 1'b0;
        for (int i = 0; i < NM; i++) begin
            if (chain_sel[i]) chain_so = seg[i][LENS[i]-1];
        end
    end

    always @(posedge clk) begin
        if (rom_clr) begin
            for (int i = 0; i < RD; i++) rom[i] <= '0;
        end else if (rom_set) begin
            rom[rom_si] <= rom_sv;
        end else if (rom_wr) begin
            rom[rom_addr] <= rom_wdata;
        end
        if (rom_rd) rom_rdata <= rom[rom_addr];
        for (int i = 0; i < NM; i++) begin
            if (seg_wr && seg_wi == i) seg[i] <= seg_wv;
            else if (chain_shift && chain_sel[i])
                seg[i] <= ((seg[i] << 1) | {15'b0, chain_si}) & lmask(i);
        end
        if (chain_shift) begin
            shift_total <= shift_total + 1;
            if ($countones(chain_sel) != 1) bad_sel <= bad_sel + 1;
            if (in_prog && chain_si !== chain_so) recirc_bad <= recirc_bad + 1;
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    int checks = 0, fails = 0;
    logic [RW-1:0] exp_rom [RD];
    logic [15:0]   exp_seg [NM];
    logic          exp_err = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic set_seg(input int i, input logic [15:0] v);
        @(negedge clk); seg_wr = 1'b1; seg_wi = i; seg_wv = v & lmask(i);
        @(negedge clk); seg_wr = 1'b0;
    endtask

    task automatic clear_rom();
        @(negedge clk); rom_clr = 1'b1;
        @(negedge clk); rom_clr = 1'b0;
        for (int i = 0; i < RD; i++) exp_rom[i] = '0;
    endtask

    task automatic put_rom(input int a, input logic [RW-1:0] v);
        @(negedge clk); rom_set = 1'b1; rom_si = a; rom_sv = v;
        @(negedge clk); rom_set = 1'b0;
        exp_rom[a] = v;
    endtask

    task automatic run_op(input bit prog);
        bit got = 1'b0;
        @(negedge clk);
        if (prog) start_prog = 1'b1; else start_load = 1'b1;
        @(negedge clk);
        start_prog = 1'b0; start_load = 1'b0;
        for (int t = 0; t < 4000; t++) begin
            if (done) begin got = 1'b1; break; end
            @(negedge clk);
        end
        if (!got) check(1'b0, "R9", "watchdog: no done", 0, 1);
        @(negedge clk);
    endtask

    function automatic int nwords(int i);
        return (LENS[i] + RW - 1) / RW;
    endfunction

    function automatic logic [RW-1:0] data_word(int i, int k, logic [15:0] v);
        logic [RW-1:0] w = '0;
        for (int b = 0; b < RW; b++) begin
            int j = k * RW + b;
            if (j < LENS[i]) w[b] = v[LENS[i]-1-j];
        end
        return w;
    endfunction

    // Expected program result per R2, R4, R5, R6
    task automatic model_program(input logic [NM-1:0] mask, output int p, output int sh);
        logic [NM-1:0] seen = '0;
        p = 0; sh = 0;
        while (p < RD && exp_rom[p][7] && exp_rom[p][6:2] == 0) begin
            seen[exp_rom[p][1:0]] = 1'b1;
            p = p + 1 + nwords(int'(exp_rom[p][1:0]));
        end
        for (int i = 0; i < NM; i++) begin
            if (mask[i] && !seen[i]) begin
                if (p + 1 + nwords(i) > RD) begin
                    exp_err = 1'b1;
                    break;
                end
                exp_rom[p] = 8'h80 | 8'(i);
                for (int k = 0; k < nwords(i); k++) exp_rom[p+1+k] = data_word(i, k, seg[i]);
                p = p + 1 + nwords(i);
                sh = sh + LENS[i];
            end
        end
    endtask

    // Expected load result per R7
    task automatic model_load(output int sh);
        int p = 0;
        sh = 0;
        for (int i = 0; i < NM; i++) exp_seg[i] = seg[i];
        while (p < RD && exp_rom[p][7] && exp_rom[p][6:2] == 0) begin
            int id = int'(exp_rom[p][1:0]);
            logic [15:0] v = '0;
            for (int j = 0; j < LENS[id]; j++)
                v[LENS[id]-1-j] = exp_rom[p+1+j/RW][j%RW];
            exp_seg[id] = v;
            sh = sh + LENS[id];
            p = p + 1 + nwords(id);
        end
    endtask

    task automatic compare_rom(input string req);
        for (int a = 0; a < RD; a++)
            check(rom[a] === exp_rom[a], req, $sformatf("rom word %0d", a), rom[a], exp_rom[a]);
    endtask

    function automatic logic [15:0] pat(int v, int i);
        return 16'(((v + 1) * 40503) ^ (i * 4951 + 77)) & lmask(i);
    endfunction

    task automatic load_and_check(input int v);
        int s0, esh;
        for (int i = 0; i < NM; i++) set_seg(i, ~pat(v, i));
        model_load(esh);
        s0 = shift_total;
        run_op(1'b0);
        for (int i = 0; i < NM; i++)
            check(seg[i] === exp_seg[i], "R7", $sformatf("loaded segment %0d", i), seg[i], exp_seg[i]);
        check(shift_total - s0 == esh, "R7", "load shift count", shift_total - s0, esh);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R9", "global watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int p, sh, s0, r0, b0, d0;
        for (int i = 0; i < RD; i++) exp_rom[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy === 1'b0, "R1", "busy", busy, 0);
        check(done === 1'b0, "R1", "done", done, 0);
        check(err_full === 1'b0, "R1", "err_full", err_full, 0);
        check(rom_wr === 1'b0 && rom_rd === 1'b0, "R1", "rom strobes", {rom_wr, rom_rd}, 0);
        check(chain_shift === 1'b0 && chain_sel === '0, "R1", "chain controls", chain_sel, 0);
        clear_rom();

        // Vector table: program passes (incremental when not cleared), each followed by a load
        for (int v = 0; v < 6; v++) begin
            if (VEC[v][9]) clear_rom();
            for (int i = 0; i < NM; i++) set_seg(i, pat(v, i));
            mem_repaired = VEC[v][8:5];
            s0 = shift_total; r0 = recirc_bad; b0 = bad_sel;
            in_prog = 1'b1;
            run_op(1'b1);
            in_prog = 1'b0;
            model_program(VEC[v][8:5], p, sh);
            compare_rom("R2 R4 R5");
            check(rom[VEC[v][4:0]] === '0 && p == int'(VEC[v][4:0]), "R5",
                  "first free word", p, VEC[v][4:0]);
            check(err_full === exp_err, "R6", "no error expected", err_full, exp_err);
            check(shift_total - s0 == sh, "R3", "unload shift count", shift_total - s0, sh);
            check(recirc_bad == r0, "R3", "recirculation mismatches", recirc_bad - r0, 0);
            for (int i = 0; i < NM; i++)
                check(seg[i] === pat(v, i), "R3", $sformatf("segment %0d kept", i), seg[i], pat(v, i));
            check(bad_sel == b0, "R8", "shift without one-hot select", bad_sel - b0, 0);
            load_and_check(v);
        end

        // R9: simultaneous starts pick program; starts while busy ignored
        clear_rom();
        for (int i = 0; i < NM; i++) set_seg(i, pat(7, i));
        mem_repaired = 4'b0001;
        s0 = shift_total; d0 = done_cnt;
        @(negedge clk); start_prog = 1'b1; start_load = 1'b1;
        @(negedge clk); start_prog = 1'b0; start_load = 1'b0;
        @(negedge clk); start_load = 1'b1;
        @(negedge clk); start_load = 1'b0; start_prog = 1'b1;
        @(negedge clk); start_prog = 1'b0;
        repeat (80) @(negedge clk);
        model_program(4'b0001, p, sh);
        compare_rom("R9");
        check(done_cnt - d0 == 1, "R9", "done pulses", done_cnt - d0, 1);
        check(busy === 1'b0, "R9", "idle afterwards", busy, 0);
        check(shift_total - s0 == LENS[0], "R9", "only program shifts", shift_total - s0, LENS[0]);

        // R6: ROM nearly full, next record does not fit
        clear_rom();
        for (int r = 0; r < 7; r++) begin
            put_rom(2 * r, 8'h81);
            put_rom(2 * r + 1, 8'h5A);
        end
        for (int i = 0; i < NM; i++) set_seg(i, pat(9, i));
        mem_repaired = 4'b0101;
        s0 = shift_total;
        run_op(1'b1);
        model_program(4'b0101, p, sh);
        compare_rom("R6");
        check(err_full === 1'b1, "R6", "full error set", err_full, 1);
        check(shift_total - s0 == 0, "R6", "no shifts on abort", shift_total - s0, 0);
        mem_repaired = 4'b0000;
        run_op(1'b1);
        check(err_full === 1'b1, "R6", "error sticky", err_full, 1);
        load_and_check(9);

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        exp_err = 1'b0;
        check(err_full === 1'b0, "R6", "error cleared by reset", err_full, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule